// File: doc/BRIEF.md
# Eight-Function 32-bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It takes two two's complement operands and a three-bit operation code. It produces one result word and two status flags taken from that result: one flag marks an all-zero result, the other marks a result whose sign bit is set. There is no clock, no reset and no stored state, so every output follows its inputs within the same evaluation.

There are eight operations. The unit can force the result to zero, apply one of three two-operand bitwise functions, invert the first operand, subtract, add, or shift the first operand left by one position. Sums and differences wrap modulo 2^DATA_W. No carry or overflow indication is produced, so the flags describe only the truncated result word.

Internally, a decoder turns the operation code into a small packed strobe struct. A datapath uses that struct to steer its logic, adder and shifter into one result. A flag stage then derives the two status bits from that result.

Top module: `alu8_core`

## Requirements
- R1: Operation code 3'b000 drives `result` to all zeros, so `zeroFlag` is 1 and `negFlag` is 0, whatever the operands are.
- R2: Code 3'b001 gives opA AND opB, code 3'b010 gives opA OR opB, and code 3'b011 gives opA XOR opB, bit by bit.
- R3: Code 3'b100 gives the bitwise complement of opA. opB has no effect on any output under this code.
- R4: Code 3'b101 gives opA minus opB, wrapped modulo 2^32. For example, 0x80000000 - 1 = 0x7FFFFFFF, and A - A = 0.
- R5: Code 3'b110 gives opA plus opB, wrapped modulo 2^32. For example, 0x7FFFFFFF + 1 = 0x80000000, and 0xFFFFFFFF + 1 = 0.
- R6: Code 3'b111 shifts opA left by exactly one bit. Bit 0 of the result is 0 and the old bit 31 is dropped, so 0x80000000 gives 0.
- R7: `zeroFlag` is 1 exactly when all 32 bits of `result` are 0, under every operation code.
- R8: `negFlag` equals bit 31 of `result` under every operation code, including the logic and shift codes.
- R9: The outputs change within the same evaluation as an input change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand, two's complement |
| opB | input | 32 | Second operand, two's complement |
| opSel | input | 3 | Operation code |
| result | output | 32 | Selected result word |
| zeroFlag | output | 1 | Result is all zeros |
| negFlag | output | 1 | Sign bit of result |

## Verification
The block holds no state, so the only internal state that can go wrong is the decoded strobe struct. A wrong strobe shows at the ports in the same evaluation as the wrong function applied to the operands, and the flags follow from that wrong word. A mis-decoded code therefore shows up on the first vector with operands that tell the two functions apart. That is why the directed operands pick values on which neighbouring functions disagree, such as carries that cross the sign bit, equal operands under subtraction, and a set top bit under the shift. Random vectors then run under every code, and all three outputs are compared against a reference model written separately from the design.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR = 3'b000,
    OP_AND   = 3'b001,
    OP_OR    = 3'b010,
    OP_XOR   = 3'b011,
    OP_INV   = 3'b100,
    OP_SUB   = 3'b101,
    OP_ADD   = 3'b110,
    OP_SHL   = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_INV = 2'd3
  } logicFn_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_ARITH = 2'd2,
    SRC_SHIFT = 2'd3
  } resSrc_e;

  typedef struct packed {
    resSrc_e  resSrc;
    logicFn_e logicFn;
    logic     subtract;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [2:0] opSel,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe = '{resSrc: SRC_NONE, logicFn: LG_AND, subtract: 1'b0};
    case (opSel)
      OP_CLEAR: strobe.resSrc = SRC_NONE;
      OP_AND:   begin strobe.resSrc = SRC_LOGIC; strobe.logicFn = LG_AND; end
      OP_OR:    begin strobe.resSrc = SRC_LOGIC; strobe.logicFn = LG_OR;  end
      OP_XOR:   begin strobe.resSrc = SRC_LOGIC; strobe.logicFn = LG_XOR; end
      OP_INV:   begin strobe.resSrc = SRC_LOGIC; strobe.logicFn = LG_INV; end
      OP_SUB:   begin strobe.resSrc = SRC_ARITH; strobe.subtract = 1'b1; end
      OP_ADD:   begin strobe.resSrc = SRC_ARITH; strobe.subtract = 1'b0; end
      OP_SHL:   strobe.resSrc = SRC_SHIFT;
      default:  strobe.resSrc = SRC_NONE;
    endcase
  end

  // R1
  always_comb begin
    if (!$isunknown(opSel)) begin
      clear_decode_chk: assert ((opSel == 3'b000) == (strobe.resSrc == SRC_NONE))
        else $error("clear decode mismatch");
    end
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobe_t        strobe,
  output logic [DATA_W-1:0] result
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] addendB;
  logic [DATA_W-1:0] carryIn;
  logic [DATA_W-1:0] arithRes;
  logic [DATA_W-1:0] shiftRes;

  // Per-bit logic cell; the function is shared by all bits.
  for (genvar bitIdx = 0; bitIdx < DATA_W; bitIdx++) begin : g_logic_cell
    always_comb begin
      case (strobe.logicFn)
        LG_AND:  logicRes[bitIdx] = opA[bitIdx] & opB[bitIdx];
        LG_OR:   logicRes[bitIdx] = opA[bitIdx] | opB[bitIdx];
        LG_XOR:  logicRes[bitIdx] = opA[bitIdx] ^ opB[bitIdx];
        default: logicRes[bitIdx] = ~opA[bitIdx];
      endcase
    end
  end

  // One adder for both add and subtract: A + ~B + 1 when subtracting.
  assign addendB  = strobe.subtract ? ~opB : opB;
  assign carryIn  = {{(DATA_W-1){1'b0}}, strobe.subtract};
  assign arithRes = opA + addendB + carryIn;

  assign shiftRes = {opA[MSB-1:0], 1'b0};

  always_comb begin
    case (strobe.resSrc)
      SRC_LOGIC: result = logicRes;
      SRC_ARITH: result = arithRes;
      SRC_SHIFT: result = shiftRes;
      default:   result = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({opA, opB, strobe})) begin
      // R5
      add_inverse_chk: assert (!(strobe.resSrc == SRC_ARITH && !strobe.subtract)
                               || (result - opB) == opA)
        else $error("add result does not invert");
      // R4
      sub_inverse_chk: assert (!(strobe.resSrc == SRC_ARITH && strobe.subtract)
                               || (result + opB) == opA)
        else $error("sub result does not invert");
      // R3
      inv_pair_chk: assert (!(strobe.resSrc == SRC_LOGIC && strobe.logicFn == LG_INV)
                            || (result ^ opA) == {DATA_W{1'b1}})
        else $error("complement mismatch");
      // R6
      shl_double_chk: assert (strobe.resSrc != SRC_SHIFT || result == opA * 2)
        else $error("shift is not doubling");
    end
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              negFlag
);

  localparam int MSB = DATA_W - 1;

  assign zeroFlag = ~|result;
  assign negFlag  = result[MSB];

  // R7
  always_comb begin
    if (!$isunknown(result)) begin
      flag_excl_chk: assert ($onehot0({zeroFlag, negFlag}))
        else $error("zero and negative both set");
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opSel,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              negFlag
);

  aluStrobe_t strobe;

  alu8_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu8_datapath #(.DATA_W(DATA_W)) u_datapath (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result)
  );

  alu8_flags #(.DATA_W(DATA_W)) u_flags (
    .result   (result),
    .zeroFlag (zeroFlag),
    .negFlag  (negFlag)
  );

  // R1
  always_comb begin
    if (!$isunknown({opSel, zeroFlag, negFlag})) begin
      clear_flags_chk: assert (opSel != 3'b000 || (zeroFlag && !negFlag))
        else $error("clear code flags wrong");
    end
  end

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opSel = '0;
  logic [31:0] result;
  logic        zeroFlag;
  logic        negFlag;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  alu8_core dut_i (
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .result   (result),
    .zeroFlag (zeroFlag),
    .negFlag  (negFlag)
  );

  function automatic logic [31:0] refModel(input logic [2:0] s,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    case (s)
      3'b001:  return a & b;
      3'b010:  return a | b;
      3'b011:  return a ^ b;
      3'b100:  return ~a;
      3'b101:  return a - b;
      3'b110:  return a + b;
      3'b111:  return a << 1;
      default: return 32'h0;
    endcase
  endfunction

  // Drive at the falling edge, compare 2 ns later.
  task automatic applyCheck(input string req, input logic [2:0] s,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] expY);
    logic expZ;
    logic expN;
    @(negedge clk);
    opSel = s; opA = a; opB = b;
    #2;
    expZ = (expY == 32'h0);
    expN = expY[31];
    vecCount++;
    if (result !== expY || zeroFlag !== expZ || negFlag !== expN) begin
      failCount++;
      $display("FAIL %s: sel=%b A=%h B=%h Y=%h exp %h Z=%b exp %b N=%b exp %b",
               req, s, a, b, result, expY, zeroFlag, expZ, negFlag, expN);
    end
  endtask

  task automatic testIdle();
    // initial inputs are all zero with code 000
    #2;
    vecCount++;
    if (result !== 32'h0 || zeroFlag !== 1'b1 || negFlag !== 1'b0) begin
      failCount++;
      $display("FAIL R1 idle: Y=%h exp 0 Z=%b exp 1 N=%b exp 0", result, zeroFlag, negFlag);
    end
  endtask

  task automatic testClear();
    applyCheck("R1", 3'b000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0);
    applyCheck("R1", 3'b000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0);
  endtask

  task automatic testLogic();
    applyCheck("R2 and", 3'b001, 32'hF0F0_1234, 32'hFF00_FF0F, 32'hF000_1204);
    applyCheck("R2 or",  3'b010, 32'h0F00_0001, 32'h00F0_8000, 32'h0FF0_8001);
    applyCheck("R2 xor", 3'b011, 32'hAAAA_5555, 32'hFFFF_0000, 32'h5555_5555);
    applyCheck("R2 and zero", 3'b001, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0);
    applyCheck("R8 or neg", 3'b010, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001);
  endtask

  task automatic testInvert();
    applyCheck("R3", 3'b100, 32'h0000_0000, 32'h1111_1111, 32'hFFFF_FFFF);
    applyCheck("R3 B ignored", 3'b100, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    applyCheck("R3", 3'b100, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0);
  endtask

  task automatic testArith();
    applyCheck("R5 signed wrap", 3'b110, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000);
    applyCheck("R5 carry drop",  3'b110, 32'hFFFF_FFFF, 32'h1, 32'h0);
    applyCheck("R4 signed wrap", 3'b101, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF);
    applyCheck("R4 equal",       3'b101, 32'h1357_9BDF, 32'h1357_9BDF, 32'h0);
    applyCheck("R4 borrow",      3'b101, 32'h0, 32'h1, 32'hFFFF_FFFF);
  endtask

  task automatic testShift();
    applyCheck("R6 msb drop", 3'b111, 32'h8000_0000, 32'h0, 32'h0);
    applyCheck("R6 into msb", 3'b111, 32'h4000_0001, 32'hFFFF_FFFF, 32'h8000_0002);
    applyCheck("R6 fill",     3'b111, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFE);
  endtask

  task automatic testNoClock();
    // R9: change inputs mid-cycle, away from any edge
    @(posedge clk);
    #5;
    opSel = 3'b110; opA = 32'd40; opB = 32'd2;
    #1;
    vecCount++;
    if (result !== 32'd42 || zeroFlag !== 1'b0 || negFlag !== 1'b0) begin
      failCount++;
      $display("FAIL R9: Y=%h exp %h", result, 32'd42);
    end
    opSel = 3'b101; opB = 32'd41;
    #1;
    vecCount++;
    if (result !== 32'hFFFF_FFFF || negFlag !== 1'b1) begin
      failCount++;
      $display("FAIL R9: Y=%h exp ffffffff N=%b exp 1", result, negFlag);
    end
  endtask

  task automatic testRandom();
    // R7 R8 over every code
    for (int code = 0; code < 8; code++) begin
      for (int n = 0; n < 200; n++) begin
        logic [31:0] a;
        logic [31:0] b;
        a = $urandom;
        b = (n % 16 == 0) ? a : $urandom;
        applyCheck("R7/R8 random", code[2:0], a, b, refModel(code[2:0], a, b));
      end
    end
  endtask

  initial begin
    testIdle();
    testClear();
    testLogic();
    testInvert();
    testArith();
    testShift();
    testNoClock();
    testRandom();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule